// File: doc/BRIEF.md
# Knockout Contention Resolution Unit

This block settles, once per time slot, which head-of-line cells in a small cell switch reach their destination output. Every input port holding a cell offers it every slot, with a destination output index and a count of how many slots in a row that cell has already lost. Each output owns a fixed number of links and so accepts up to that many cells per slot. Cells with more consecutive losses win first, which keeps the cells of one connection in order; equal counts go to the lower input index.

A losing cell is not held at its own input. It is sent back into another input port, one not taken by a fresh head-of-line cell next slot, carrying a loss count raised by one. When the raised count reaches the discard limit, or no port can take it, the cell is dropped. The decision is combinational from the slot inputs and is captured on the slot strobe. The results are flagged valid for the one cycle that follows.

A two-state controller sequences this. State `ST_WAIT` holds the last results with the valid flag low. The transition `capture` (slot strobe high) moves either state to `ST_SHOW`, in which the valid flag is high. The transition `release` (strobe low) returns `ST_SHOW` to `ST_WAIT`.

Top module: `knockout_arbiter`

## Requirements
- R1: After reset, `out_vld`, every status bit and every link grant bit are 0.
- R2: `out_vld` is 1 in exactly the cycle after a cycle with `slot_go` high, and 0 otherwise.
- R3: Each output grants at most LINKS cells per slot. When fewer than LINKS valid cells target an output, all of them win.
- R4: Among cells to the same output, a larger `cell_loss` wins over a smaller one. Equal counts favour the lower input index.
- R5: Winners take links in priority order, link 0 first. Grant bit `link_vld[o][l]` (flat bit o*LINKS+l) is set and `link_src[o][l]` holds the winning input index.
- R6: A winning cell reports `stat_won` with `stat_loss` equal to 0.
- R7: A losing cell reports `stat_loss` = `cell_loss`+1. If that value is at least DROP_LIM (default 3), it reports `stat_drop` instead of being deflected.
- R8: Losers are handled in rising input index. Each one takes the first port after its own index, modulo NUM_IN and never its own, whose `hol_busy` bit is 0 and which no lower-index loser has taken. The cell reports `stat_defl` and that port on `stat_port`.
- R9: A loser under the limit that finds no free port reports `stat_drop`.
- R10: An input with `cell_vld` low gets no status bit and no grant.
- R11: Every valid input gets exactly one of `stat_won`, `stat_defl` and `stat_drop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_go | input | 1 | Slot strobe: captures the decision |
| cell_vld | input | NUM_IN | Input holds a cell this slot |
| cell_dst | input | NUM_IN×DEST_W | Destination output per input |
| cell_loss | input | NUM_IN×CNT_W | Consecutive losses so far per input |
| hol_busy | input | NUM_IN | Port already has a new head-of-line cell next slot |
| out_vld | output | 1 | Results valid this cycle |
| link_vld | output | N_OUT×LINKS | Grant per output link, bit o*LINKS+l |
| link_src | output | N_OUT×LINKS×IDX_W | Winning input index per output link |
| stat_won | output | NUM_IN | Cell reached its output |
| stat_defl | output | NUM_IN | Cell sent back into another input |
| stat_drop | output | NUM_IN | Cell discarded |
| stat_port | output | NUM_IN×IDX_W | Re-injection port of a deflected cell |
| stat_loss | output | NUM_IN×CNT_W | Updated loss count |

## Verification
The assertions take for granted that `cell_loss` on a valid input stays below DROP_LIM, since a cell at the limit would already have been discarded. They also take for granted that `slot_go` is low while reset is applied. The directed stimulus sets every loss count to 0, 1 or 2 with the default limit of 3, and it raises the strobe only after reset has been released. The scenarios cover full contention with port exhaustion, mixed priorities, the drop threshold, wrap-around of the deflection search and an empty slot.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_SHOW = 1'b1
    } kcr_state_e;
endpackage

// File: rtl/kcr_fsm.sv
module kcr_fsm
    import kcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_go,
    output logic capture,
    output logic show
);
    kcr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (slot_go) state_d = ST_SHOW;
            ST_SHOW: state_d = slot_go ? ST_SHOW : ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        capture = slot_go;
        show    = (state_q == ST_SHOW);
    end
endmodule

// File: rtl/kcr_rank.sv
module kcr_rank #(
    parameter int NUM_IN = 8,
    parameter int LINKS  = 3,
    parameter int DEST_W = 3,
    parameter int CNT_W  = 2,
    localparam int IDX_W = $clog2(NUM_IN),
    localparam int N_OUT = 1 << DEST_W,
    localparam int RK_W  = $clog2(NUM_IN + 1)
) (
    input  logic [NUM_IN-1:0]                        vld,
    input  logic [NUM_IN-1:0][DEST_W-1:0]            dst,
    input  logic [NUM_IN-1:0][CNT_W-1:0]             loss,
    output logic [NUM_IN-1:0]                        won,
    output logic [N_OUT-1:0][LINKS-1:0]              lvld,
    output logic [N_OUT-1:0][LINKS-1:0][IDX_W-1:0]   lsrc
);
    logic [NUM_IN-1:0][RK_W-1:0] rank;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_rank
        always_comb begin
            rank[i] = '0;
            for (int j = 0; j < NUM_IN; j++) begin
                if (j != i && vld[j] && dst[j] == dst[i] &&
                    (loss[j] > loss[i] || (loss[j] == loss[i] && j < i)))
                    rank[i] = rank[i] + RK_W'(1);
            end
            won[i] = vld[i] && (int'(rank[i]) < LINKS);
        end
    end

    always_comb begin
        lvld = '0;
        lsrc = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int i = 0; i < NUM_IN; i++) begin
                for (int l = 0; l < LINKS; l++) begin
                    if (won[i] && int'(dst[i]) == o && int'(rank[i]) == l) begin
                        lvld[o][l] = 1'b1;
                        lsrc[o][l] = IDX_W'(i);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/kcr_deflect.sv
module kcr_deflect #(
    parameter int NUM_IN   = 8,
    parameter int CNT_W    = 2,
    parameter int DROP_LIM = 3,
    localparam int IDX_W   = $clog2(NUM_IN),
    localparam int CNT_MAX = (1 << CNT_W) - 1
) (
    input  logic [NUM_IN-1:0]              vld,
    input  logic [NUM_IN-1:0]              won,
    input  logic [NUM_IN-1:0][CNT_W-1:0]   loss,
    input  logic [NUM_IN-1:0]              hol_busy,
    output logic [NUM_IN-1:0]              defl,
    output logic [NUM_IN-1:0]              drop,
    output logic [NUM_IN-1:0][IDX_W-1:0]   port,
    output logic [NUM_IN-1:0][CNT_W-1:0]   new_loss
);
    logic [NUM_IN-1:0] taken;
    logic [CNT_W:0]    inc;
    logic              found;
    int                p;

    always_comb begin
        taken    = '0;
        defl     = '0;
        drop     = '0;
        port     = '0;
        new_loss = '0;
        inc      = '0;
        found    = 1'b0;
        p        = 0;
        for (int i = 0; i < NUM_IN; i++) begin
            inc   = {1'b0, loss[i]} + (CNT_W+1)'(1);
            found = 1'b0;
            if (vld[i] && !won[i]) begin
                new_loss[i] = (int'(inc) > CNT_MAX) ? CNT_W'(CNT_MAX) : inc[CNT_W-1:0];
                if (int'(inc) >= DROP_LIM) begin
                    drop[i] = 1'b1;
                end else begin
                    for (int off = 1; off < NUM_IN; off++) begin
                        p = (i + off) % NUM_IN;
                        if (!found && !hol_busy[p] && !taken[p]) begin
                            found    = 1'b1;
                            taken[p] = 1'b1;
                            port[i]  = IDX_W'(p);
                        end
                    end
                    defl[i] = found;
                    drop[i] = !found;
                end
            end
        end
    end
endmodule

// File: rtl/knockout_arbiter.sv
module knockout_arbiter #(
    parameter int NUM_IN   = 8,
    parameter int LINKS    = 3,
    parameter int DEST_W   = 3,
    parameter int DROP_LIM = 3,
    localparam int IDX_W   = $clog2(NUM_IN),
    localparam int CNT_W   = $clog2(DROP_LIM + 1),
    localparam int N_OUT   = 1 << DEST_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   slot_go,
    input  logic [NUM_IN-1:0]                      cell_vld,
    input  logic [NUM_IN-1:0][DEST_W-1:0]          cell_dst,
    input  logic [NUM_IN-1:0][CNT_W-1:0]           cell_loss,
    input  logic [NUM_IN-1:0]                      hol_busy,
    output logic                                   out_vld,
    output logic [N_OUT-1:0][LINKS-1:0]            link_vld,
    output logic [N_OUT-1:0][LINKS-1:0][IDX_W-1:0] link_src,
    output logic [NUM_IN-1:0]                      stat_won,
    output logic [NUM_IN-1:0]                      stat_defl,
    output logic [NUM_IN-1:0]                      stat_drop,
    output logic [NUM_IN-1:0][IDX_W-1:0]           stat_port,
    output logic [NUM_IN-1:0][CNT_W-1:0]           stat_loss
);
    logic                                   capture;
    logic [NUM_IN-1:0]                      won_c, defl_c, drop_c;
    logic [NUM_IN-1:0][IDX_W-1:0]           port_c;
    logic [NUM_IN-1:0][CNT_W-1:0]           loss_c;
    logic [N_OUT-1:0][LINKS-1:0]            lvld_c;
    logic [N_OUT-1:0][LINKS-1:0][IDX_W-1:0] lsrc_c;

    kcr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_go (slot_go),
        .capture (capture),
        .show    (out_vld)
    );

    kcr_rank #(
        .NUM_IN (NUM_IN), .LINKS (LINKS), .DEST_W (DEST_W), .CNT_W (CNT_W)
    ) u_rank (
        .vld  (cell_vld),
        .dst  (cell_dst),
        .loss (cell_loss),
        .won  (won_c),
        .lvld (lvld_c),
        .lsrc (lsrc_c)
    );

    kcr_deflect #(
        .NUM_IN (NUM_IN), .CNT_W (CNT_W), .DROP_LIM (DROP_LIM)
    ) u_defl (
        .vld      (cell_vld),
        .won      (won_c),
        .loss     (cell_loss),
        .hol_busy (hol_busy),
        .defl     (defl_c),
        .drop     (drop_c),
        .port     (port_c),
        .new_loss (loss_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_vld  <= '0;
            link_src  <= '0;
            stat_won  <= '0;
            stat_defl <= '0;
            stat_drop <= '0;
            stat_port <= '0;
            stat_loss <= '0;
        end else if (capture) begin
            link_vld  <= lvld_c;
            link_src  <= lsrc_c;
            stat_won  <= won_c;
            stat_defl <= defl_c;
            stat_drop <= drop_c;
            stat_port <= port_c;
            stat_loss <= loss_c;
        end
    end
endmodule

// File: rtl/kcr_chk.sv
module kcr_chk #(
    parameter int NUM_IN   = 8,
    parameter int LINKS    = 3,
    parameter int DEST_W   = 3,
    parameter int DROP_LIM = 3,
    localparam int IDX_W   = $clog2(NUM_IN),
    localparam int CNT_W   = $clog2(DROP_LIM + 1),
    localparam int N_OUT   = 1 << DEST_W
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   slot_go,
    input logic [NUM_IN-1:0]                      cell_vld,
    input logic [NUM_IN-1:0][CNT_W-1:0]           cell_loss,
    input logic [NUM_IN-1:0]                      hol_busy,
    input logic                                   out_vld,
    input logic [N_OUT-1:0][LINKS-1:0]            link_vld,
    input logic [NUM_IN-1:0]                      stat_won,
    input logic [NUM_IN-1:0]                      stat_defl,
    input logic [NUM_IN-1:0]                      stat_drop,
    input logic [NUM_IN-1:0][IDX_W-1:0]           stat_port,
    input logic [NUM_IN-1:0][CNT_W-1:0]           stat_loss
);
    logic                            go_q;
    logic [NUM_IN-1:0]               vld_q, busy_q;
    logic [NUM_IN-1:0][CNT_W-1:0]    loss_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            vld_q  <= '0;
            busy_q <= '0;
            loss_q <= '0;
        end else begin
            go_q <= slot_go;
            if (slot_go) begin
                vld_q  <= cell_vld;
                busy_q <= hol_busy;
                loss_q <= cell_loss;
            end
        end
    end

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == go_q);

    p_grant_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $countones(stat_won) == $countones(link_vld));

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        p_one_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> $countones({stat_won[i], stat_defl[i], stat_drop[i]})
                        == (vld_q[i] ? 1 : 0));

        p_won_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld && stat_won[i]) |-> stat_loss[i] == '0);

        p_defl_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld && stat_defl[i]) |->
                (int'(stat_loss[i]) == int'(loss_q[i]) + 1) &&
                (int'(stat_loss[i]) < DROP_LIM));

        p_defl_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld && stat_defl[i]) |->
                !busy_q[stat_port[i]] && (int'(stat_port[i]) != i));
    end
endmodule

bind knockout_arbiter kcr_chk #(
    .NUM_IN (NUM_IN), .LINKS (LINKS), .DEST_W (DEST_W), .DROP_LIM (DROP_LIM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_go   (slot_go),
    .cell_vld  (cell_vld),
    .cell_loss (cell_loss),
    .hol_busy  (hol_busy),
    .out_vld   (out_vld),
    .link_vld  (link_vld),
    .stat_won  (stat_won),
    .stat_defl (stat_defl),
    .stat_drop (stat_drop),
    .stat_port (stat_port),
    .stat_loss (stat_loss)
);

// File: tb/sim_knockout_arbiter.sv
`timescale 1ns/1ps
module sim_knockout_arbiter;
    localparam int K  = 8;
    localparam int L  = 3;
    localparam int DW = 3;
    localparam int IW = 3;
    localparam int CW = 2;
    localparam int NO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_go = 1'b0;
    logic [K-1:0]              cell_vld = '0;
    logic [K-1:0][DW-1:0]      cell_dst = '0;
    logic [K-1:0][CW-1:0]      cell_loss = '0;
    logic [K-1:0]              hol_busy = '0;
    logic                      out_vld;
    logic [NO-1:0][L-1:0]      link_vld;
    logic [NO-1:0][L-1:0][IW-1:0] link_src;
    logic [K-1:0]              stat_won, stat_defl, stat_drop;
    logic [K-1:0][IW-1:0]      stat_port;
    logic [K-1:0][CW-1:0]      stat_loss;

    knockout_arbiter u0 (.*);

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int e_code [K];
    int e_loss [K];
    int e_port [K];
    int e_src  [NO*L];
    logic [NO*L-1:0] e_lv;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        cell_vld = '0; cell_dst = '0; cell_loss = '0; hol_busy = '0;
        e_lv = '0;
        for (int i = 0; i < K; i++) begin
            e_code[i] = 0; e_loss[i] = 0; e_port[i] = 0;
        end
        for (int n = 0; n < NO*L; n++) e_src[n] = 0;
    endtask

    task automatic put(int i, int d, int ls);
        cell_vld[i]  = 1'b1;
        cell_dst[i]  = DW'(d);
        cell_loss[i] = CW'(ls);
    endtask

    // code: 1 won, 2 deflected, 4 dropped
    task automatic expect_in(int i, int code, int ls, int pt);
        e_code[i] = code; e_loss[i] = ls; e_port[i] = pt;
    endtask

    task automatic expect_link(int o, int l, int src);
        e_lv[o*L+l] = 1'b1;
        e_src[o*L+l] = src;
    endtask

    task automatic run_slot(string tag);
        @(negedge clk);
        slot_go = 1'b1;
        @(negedge clk);
        slot_go = 1'b0;
        chk({tag, " R2 out_vld high"}, int'(out_vld), 1);
        for (int i = 0; i < K; i++) begin
            chk({tag, " R11 status"}, int'({stat_drop[i], stat_defl[i], stat_won[i]}), e_code[i]);
            if (e_code[i] != 0) chk({tag, " R7 loss"}, int'(stat_loss[i]), e_loss[i]);
            if (e_code[i] == 2) chk({tag, " R8 port"}, int'(stat_port[i]), e_port[i]);
        end
        chk({tag, " R5 grant bits"}, int'(link_vld), int'(e_lv));
        for (int n = 0; n < NO*L; n++)
            if (e_lv[n]) chk({tag, " R5 link src"}, int'(link_src[n/L][n%L]), e_src[n]);
        @(negedge clk);
        chk({tag, " R2 out_vld low after"}, int'(out_vld), 0);
    endtask

    task automatic t_reset();
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 won", int'(stat_won), 0);
        chk("R1 defl", int'(stat_defl), 0);
        chk("R1 drop", int'(stat_drop), 0);
        chk("R1 grants", int'(link_vld), 0);
        repeat (3) @(negedge clk);
        chk("R2 no strobe", int'(out_vld), 0);
    endtask

    task automatic t_full_contention();
        clear_all();
        for (int i = 0; i < K; i++) put(i, 2, 0);
        hol_busy = 8'b0000_1111;
        for (int i = 0; i < 3; i++) begin
            expect_in(i, 1, 0, 0);
            expect_link(2, i, i);
        end
        for (int i = 3; i < 7; i++) expect_in(i, 2, 1, i + 1);
        expect_in(7, 4, 1, 0);   // R9 no free port left
        run_slot("R3 R9 full");
    endtask

    task automatic t_priority();
        clear_all();
        put(0, 5, 0); put(1, 5, 2); put(2, 5, 1); put(3, 5, 1); put(4, 5, 0);
        expect_in(1, 1, 0, 0); expect_link(5, 0, 1);
        expect_in(2, 1, 0, 0); expect_link(5, 1, 2);
        expect_in(3, 1, 0, 0); expect_link(5, 2, 3);
        expect_in(0, 2, 1, 1);
        expect_in(4, 2, 1, 5);
        run_slot("R4 R10 priority");
    endtask

    task automatic t_threshold();
        clear_all();
        for (int i = 0; i < 4; i++) put(i, 0, 2);
        put(4, 1, 2);
        put(5, 0, 1);
        for (int i = 0; i < 3; i++) begin
            expect_in(i, 1, 0, 0);
            expect_link(0, i, i);
        end
        expect_in(3, 4, 3, 0);
        expect_in(4, 1, 0, 0); expect_link(1, 0, 4);
        expect_in(5, 2, 2, 6);
        run_slot("R7 R6 threshold");
    endtask

    task automatic t_spread();
        clear_all();
        for (int i = 0; i < K; i++) begin
            put(i, i, i % 3);
            expect_in(i, 1, 0, 0);
            expect_link(i, 0, i);
        end
        run_slot("R3 R6 spread");
    endtask

    task automatic t_wrap();
        clear_all();
        put(7, 3, 2);
        for (int i = 0; i < 4; i++) put(i, 3, 0);
        hol_busy = 8'b1111_1000;
        expect_in(7, 1, 0, 0); expect_link(3, 0, 7);
        expect_in(0, 1, 0, 0); expect_link(3, 1, 0);
        expect_in(1, 1, 0, 0); expect_link(3, 2, 1);
        expect_in(2, 2, 1, 0);
        expect_in(3, 2, 1, 1);
        run_slot("R8 R4 wrap");
    endtask

    task automatic t_empty();
        clear_all();
        hol_busy = 8'hA5;
        run_slot("R10 empty");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_contention();
        t_priority();
        t_threshold();
        t_spread();
        t_wrap();
        t_empty();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule